// File: doc/BRIEF.md
# Tagged Single-Packet Instruction Buffer

This block is a small instruction store placed next to the L0 instruction cache of a core pipeline. It holds the instructions of one instruction packet at most, together with one address tag that names the packet it holds. Fetch logic asks whether a packet address is resident. On a hit the decoder reads the instructions again from the first entry, and nothing is fetched from memory. A loop body that fits can therefore be executed many times from one fill.

A new fill is announced with a start pulse that carries the packet address. The tag is replaced and the old contents are dropped at once. The instructions that follow arrive one per beat from the memory-side channel. The beat whose end marker is set fixes the packet length. A packet longer than the store is cut at its capacity, and the caller must fetch the rest from elsewhere. Reads may begin while a fill is still running. The read side then waits for each entry to arrive before it presents it.

Top module: `pkt_ibuf`

## Requirements
- R1: After reset no tag is valid. Every lookup reports a miss and `rd_valid` is low.
- R2: A `fill_start` pulse stores `fill_addr` as the tag from the next cycle on. In the same cycle as the request, `lk_hit` is 1 for that address and 0 for any other address.
- R3: Write beats accepted after `fill_start` go to entries 0, 1, 2 and so on in order. The beat with `wr_last` = 1 sets the packet length to its index plus one. A beat in the same cycle as `fill_start` is ignored.
- R4: A lookup hit restarts reading at entry 0 from the next cycle. Each cycle with `rd_valid` and `rd_ready` both high advances one entry. While `rd_ready` is low, `rd_valid` and `rd_data` stay unchanged.
- R5: `rd_eop` is 1 exactly while the last entry of the packet is presented. Once that entry is accepted, `rd_valid` goes low and stays low until the next hit.
- R6: Repeated hits on the same tag replay the identical instruction sequence with no refill.
- R7: When a read reaches an entry that is not yet written, `rd_valid` stays low. The entry is presented in the cycle after its write beat.
- R8: When more than DEPTH beats arrive without an end marker, the first DEPTH are kept and the last of them is flagged with `rd_eop`. Later beats are ignored until the next `fill_start`.
- R9: A `fill_start` aborts any read in progress (`rd_valid` low in the next cycle), and the old tag then misses. A read that hits in the same cycle as `fill_start` is also aborted.
- R10: A lookup that misses does not disturb a read in progress. Reading continues from the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_start | input | 1 | Begin a new packet fill, replacing the tag |
| fill_addr | input | ADDR_W | Address of the packet being filled |
| wr_valid | input | 1 | Instruction beat from the memory side |
| wr_data | input | INSTR_W | Instruction word of the beat |
| wr_last | input | 1 | End-of-packet marker on the beat |
| lk_valid | input | 1 | Tag lookup request |
| lk_addr | input | ADDR_W | Packet address to look up |
| lk_hit | output | 1 | Lookup hit, same cycle as the request |
| rd_ready | input | 1 | Decoder accepts the presented instruction |
| rd_valid | output | 1 | An instruction is presented |
| rd_data | output | INSTR_W | Presented instruction |
| rd_eop | output | 1 | Presented instruction is the last of the packet |

## Verification
The hardest case to reach from the ports is a read that catches up with a fill still in progress. The stimulus writes two beats, issues a hit and drains both entries with the decoder ready. It then holds off the third beat so that the stall can be seen. The beat, with its end marker, comes in while `rd_ready` stays high, and the bench expects the entry one cycle later. A second hard case is a fill that aborts a read partway through. The bench stops the decoder after one entry, starts a new fill, and confirms that the old address misses while the new one replays.

// File: rtl/pkt_ibuf_pkg.sv
package pkt_ibuf_pkg;
    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;
endpackage

// File: rtl/ibuf_tag.sv
module ibuf_tag #(
    parameter int ADDR_W = 30,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              wr_en,
    output logic [CNT_W-1:0]  fill_cnt,
    output logic [CNT_W-1:0]  pkt_len,
    output logic              len_known
);
    import pkt_ibuf_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] tag;
        fill_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  len;
    } tag_st_t;

    tag_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_en = (st_q.state == FILL_BUSY) && wr_valid && !fill_start;
        if (fill_start) begin
            st_d.valid = 1'b1;
            st_d.tag   = fill_addr;
            st_d.state = FILL_BUSY;
            st_d.cnt   = '0;
            st_d.len   = '0;
        end else if (wr_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (wr_last || (st_q.cnt == CNT_W'(DEPTH - 1))) begin
                st_d.state = FILL_IDLE;
                st_d.len   = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, tag: '0, state: FILL_IDLE, cnt: '0, len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit    = lk_valid && st_q.valid && (st_q.tag == lk_addr);
    assign fill_cnt  = st_q.cnt;
    assign pkt_len   = st_q.len;
    assign len_known = (st_q.state == FILL_IDLE);

    // R2: a fill pulse installs its address as the valid tag
    assert_fill_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |=> (st_q.valid && st_q.tag == $past(fill_addr)));

    // R3: the marked beat fixes the length as its index plus one
    assert_len_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |=> (len_known && pkt_len == $past(st_q.cnt) + CNT_W'(1)));

    // R8: the write index never runs past the capacity
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == FILL_BUSY) |-> (st_q.cnt < CNT_W'(DEPTH)));

    // R1: a lookup never hits without a valid tag
    assert_hit_needs_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> st_q.valid);
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store #(
    parameter int DEPTH   = 16,
    parameter int INSTR_W = 32,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_idx,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic [CNT_W-1:0]   rd_idx,
    output logic [INSTR_W-1:0] rd_data
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [INSTR_W-1:0] mem_q [DEPTH];
    logic [INSTR_W-1:0] mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_idx == CNT_W'(g))) begin
                mem_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx < CNT_W'(DEPTH)) begin
            rd_data = mem_q[rd_idx[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/ibuf_reader.sv
module ibuf_reader #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic             len_known,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic             rd_eop,
    output logic [CNT_W-1:0] rd_idx
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] ptr;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        rd_valid = st_q.active && (st_q.ptr < fill_cnt);
        rd_eop   = rd_valid && len_known && (st_q.ptr == pkt_len - CNT_W'(1));
        st_d     = st_q;
        if (abort) begin
            st_d.active = 1'b0;
            st_d.ptr    = '0;
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.ptr    = '0;
        end else if (rd_valid && rd_ready) begin
            if (rd_eop) begin
                st_d.active = 1'b0;
            end else begin
                st_d.ptr = st_q.ptr + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.ptr;

    // R4: a hit restarts at entry 0
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (rd_idx == '0));

    // R4: an accepted non-final entry advances by exactly one
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_eop && !start && !abort)
        |=> (rd_idx == $past(rd_idx) + CNT_W'(1)));

    // R5: accepting the final entry ends the read
    assert_eop_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_eop && !start && !abort) |=> !rd_valid);

    // R9: a fill pulse stops any read
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !rd_valid);
endmodule

// File: rtl/pkt_ibuf.sv
module pkt_ibuf #(
    parameter int ADDR_W  = 30,
    parameter int INSTR_W = 32,
    parameter int DEPTH   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_start,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic               wr_valid,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic               wr_last,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_hit,
    input  logic               rd_ready,
    output logic               rd_valid,
    output logic [INSTR_W-1:0] rd_data,
    output logic               rd_eop
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] pkt_len;
    logic             len_known;
    logic [CNT_W-1:0] rd_idx;

    ibuf_tag #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_start(fill_start),
        .fill_addr (fill_addr),
        .wr_valid  (wr_valid),
        .wr_last   (wr_last),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .wr_en     (wr_en),
        .fill_cnt  (fill_cnt),
        .pkt_len   (pkt_len),
        .len_known (len_known)
    );

    ibuf_store #(.DEPTH(DEPTH), .INSTR_W(INSTR_W), .CNT_W(CNT_W)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (fill_cnt),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    ibuf_reader #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (lk_hit),
        .abort    (fill_start),
        .fill_cnt (fill_cnt),
        .pkt_len  (pkt_len),
        .len_known(len_known),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_eop   (rd_eop),
        .rd_idx   (rd_idx)
    );
endmodule

// File: tb/test_pkt_ibuf.sv
module test_pkt_ibuf;
    localparam int ADDR_W  = 30;
    localparam int INSTR_W = 32;
    localparam int DEPTH   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fill_start = 1'b0;
    logic [ADDR_W-1:0]  fill_addr = '0;
    logic               wr_valid = 1'b0;
    logic [INSTR_W-1:0] wr_data = '0;
    logic               wr_last = 1'b0;
    logic               lk_valid = 1'b0;
    logic [ADDR_W-1:0]  lk_addr = '0;
    logic               lk_hit;
    logic               rd_ready = 1'b0;
    logic               rd_valid;
    logic [INSTR_W-1:0] rd_data;
    logic               rd_eop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pkt_ibuf #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .DEPTH(DEPTH)) i_pkt_ibuf (
        .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_addr(fill_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eop(rd_eop)
    );

    function automatic logic [INSTR_W-1:0] word(input int addr, input int idx);
        return {addr[15:0], idx[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [INSTR_W-1:0] act,
                         input logic [INSTR_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // fill a packet of n beats; the marker goes on beat last_at (1-based), 0 = none
    task automatic fill_pkt(input int addr, input int n, input int last_at);
        @(negedge clk);
        fill_start = 1'b1;
        fill_addr  = ADDR_W'(addr);
        @(negedge clk);
        fill_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = word(addr, i);
            wr_last  = (i == last_at - 1);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    // leaves the bench at the negedge after the registered lookup
    task automatic lookup(input int addr, input bit exp_hit, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = ADDR_W'(addr);
        #1;
        check(lk_hit == exp_hit, req, 32'(lk_hit), 32'(exp_hit));
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic read_pkt(input int addr, input int n, input int first, input string req);
        for (int i = first; i < n; i++) begin
            rd_ready = 1'b1;
            #1;
            check(rd_valid == 1'b1, {req, " valid"}, 32'(rd_valid), 32'd1);
            check(rd_data == word(addr, i), {req, " data"}, rd_data, word(addr, i));
            check(rd_eop == (i == n - 1), {req, " eop"}, 32'(rd_eop), 32'(i == n - 1));
            @(negedge clk);
        end
        rd_ready = 1'b0;
        #1;
        check(rd_valid == 1'b0, {req, " stop after end"}, 32'(rd_valid), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = '0;
        #1;
        check(lk_hit == 1'b0, "R1 lookup miss at reset", 32'(lk_hit), 32'd0);
        check(rd_valid == 1'b0, "R1 no read at reset", 32'(rd_valid), 32'd0);
        lk_valid = 1'b0;
        rst_n    = 1'b1;
        lookup(0, 1'b0, "R1 lookup miss after reset");
    endtask

    task automatic t_basic;
        fill_pkt(5, 6, 6);
        lookup(7, 1'b0, "R2 other address misses");
        lookup(5, 1'b1, "R2 filled address hits");
        read_pkt(5, 6, 0, "R3 R4 R5 basic read");
    endtask

    task automatic t_hold;
        lookup(5, 1'b1, "R4 hit before hold");
        rd_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
            #1;
            check(rd_valid == 1'b1 && rd_data == word(5, 0), "R4 hold entry 0",
                  rd_data, word(5, 0));
            @(negedge clk);
        end
        read_pkt(5, 6, 0, "R4 read after hold");
    endtask

    task automatic t_replay;
        for (int k = 0; k < 2; k++) begin
            lookup(5, 1'b1, "R6 replay hit");
            read_pkt(5, 6, 0, "R6 replay read");
        end
    endtask

    task automatic t_single;
        fill_pkt(9, 1, 1);
        lookup(9, 1'b1, "R5 single hit");
        read_pkt(9, 1, 0, "R5 single entry");
    endtask

    task automatic t_overflow;
        fill_pkt(11, DEPTH + 4, 0);
        lookup(11, 1'b1, "R8 long packet hit");
        read_pkt(11, DEPTH, 0, "R8 truncated read");
    endtask

    task automatic t_stall;
        @(negedge clk);
        fill_start = 1'b1;
        fill_addr  = ADDR_W'(20);
        @(negedge clk);
        fill_start = 1'b0;
        wr_valid   = 1'b1;
        wr_data    = word(20, 0);
        @(negedge clk);
        wr_data    = word(20, 1);
        @(negedge clk);
        wr_valid   = 1'b0;
        lookup(20, 1'b1, "R7 hit during fill");
        rd_ready = 1'b1;
        for (int i = 0; i < 2; i++) begin
            #1;
            check(rd_valid && rd_data == word(20, i) && !rd_eop, "R7 written entry",
                  rd_data, word(20, i));
            @(negedge clk);
        end
        #1;
        check(rd_valid == 1'b0, "R7 stall on unwritten entry", 32'(rd_valid), 32'd0);
        wr_valid = 1'b1;
        wr_data  = word(20, 2);
        wr_last  = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        #1;
        check(rd_valid && rd_data == word(20, 2), "R7 entry after its write",
              rd_data, word(20, 2));
        check(rd_eop == 1'b1, "R7 eop on late entry", 32'(rd_eop), 32'd1);
        @(negedge clk);
        rd_ready = 1'b0;
        #1;
        check(rd_valid == 1'b0, "R7 stop after late entry", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_miss_midread;
        fill_pkt(3, 4, 4);
        lookup(3, 1'b1, "R10 hit");
        rd_ready = 1'b1;
        #1;
        check(rd_data == word(3, 0), "R10 first entry", rd_data, word(3, 0));
        @(negedge clk);
        rd_ready = 1'b0;
        lookup(8, 1'b0, "R10 miss during read");
        read_pkt(3, 4, 1, "R10 read continues");
    endtask

    task automatic t_overwrite;
        lookup(3, 1'b1, "R9 hit old packet");
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready   = 1'b0;
        fill_start = 1'b1;
        fill_addr  = ADDR_W'(12);
        @(negedge clk);
        fill_start = 1'b0;
        #1;
        check(rd_valid == 1'b0, "R9 read aborted", 32'(rd_valid), 32'd0);
        wr_valid = 1'b1;
        wr_data  = word(12, 0);
        @(negedge clk);
        wr_data  = word(12, 1);
        wr_last  = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        lookup(3, 1'b0, "R9 old tag misses");
        lookup(12, 1'b1, "R9 new tag hits");
        read_pkt(12, 2, 0, "R9 new packet read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_basic;
        t_hold;
        t_replay;
        t_single;
        t_overflow;
        t_stall;
        t_miss_midread;
        t_overwrite;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule